// File: doc/BRIEF.md
# Boot Sector Load Sequencer

This block runs the cold-start load of a floppy-style boot drive. A single start pulse in the idle state begins the sequence. The block first raises four drive control levels one cycle apart. It then moves the head back to track 0 with a fixed burst of outward phase steps, and each step is followed by a settle time that software sets. After that it asks an external field reader for sectors 0, 1, 2 and so on, and gives each sector its own destination page. The field reader searches for the sector and decodes it.

The first byte of the first good sector tells the block how many sectors to load. The block keeps a counter that rises by one for each good sector, and loading continues while this counter is below that count. A count of 0 therefore loads one sector, and so does a count of 1. When loading ends, the block shows a jump target one byte past the load base, together with a register value equal to the slot number times 16.

Both sector transfers use valid/ready handshakes. A request is offered on `req_valid` and is taken on the cycle where `req_ready` is also high. Until then the request fields stay still, so the reader may apply back-pressure for as long as it needs. After a request is taken, the block holds `resp_ready` high and waits for exactly one response, however many cycles that takes. A response with `resp_ok` low means a bad checksum or a header mismatch. In that case the same sector and page are requested again, and there is no limit on retries.

Top module: `boot_load_seq`

## Requirements
- R1: While reset is held and right after it, every drive level, `step_pulse`, `req_valid`, `resp_ready` and `jump_valid` is 0, and `status` is 0 (idle).
- R2: A start accepted in idle raises `rd_mode` after the first clock edge, `latch_mode` after the second, `drive1_sel` after the third and `motor_on` after the fourth. Each level, once raised, stays high until reset.
- R3: After `motor_on` is high, exactly NUM_STEPS (default 80) cycles of `step_pulse` occur, and all of them come before the first request. Each pulse lasts one cycle. Between pulses there are `settle_cycles` low cycles, so successive pulses are `settle_cycles`+1 cycles apart.
- R4: The n-th distinct sector requested, counting from n = 0, has `req_sector` = n and `req_page` = 8 + n, so the first request is sector 0 to page 0x08.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_sector` and `req_page` hold their values. `resp_ready` is high only after a request has been taken and before its response arrives.
- R6: A response taken with `resp_ok` = 0 is followed by a request for the same sector and page. Any number of failures is allowed.
- R7: The count is `resp_byte0` of the first good response. The total number of good sectors loaded is the maximum of 1 and that count. `resp_byte0` on later responses has no effect.
- R8: Once the last sector is in, `jump_valid` goes high. At that point `jump_addr` = 0x0801 and `jump_x` = 16 × the `slot_id` value sampled at start, and no further request is made.
- R9: `status` reads 1 (seek) from the accepted start until the steps end, 2 (load) while sectors are requested, and 3 (done) once `jump_valid` is high, where it stays.
- R10: `start` is ignored outside idle; pulsing it during load does not change `status` or the sector order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin sequence (idle only) |
| slot_id | input | 3 | Slot number, sampled at start |
| settle_cycles | input | 16 | Low cycles after each step pulse |
| rd_mode | output | 1 | Drive read mode select |
| latch_mode | output | 1 | Data latch mode select |
| drive1_sel | output | 1 | Drive 1 select |
| motor_on | output | 1 | Spindle motor enable |
| step_pulse | output | 1 | One outward head phase step |
| req_valid | output | 1 | Sector request offered |
| req_ready | input | 1 | Field reader takes the request |
| req_sector | output | 8 | Sector number wanted (track 0) |
| req_page | output | 8 | Destination page for the sector |
| resp_valid | input | 1 | Sector result offered |
| resp_ready | output | 1 | Waiting for a sector result |
| resp_ok | input | 1 | Sector read good (checksum and header) |
| resp_byte0 | input | 8 | First data byte of the sector |
| jump_valid | output | 1 | Load finished, jump target valid |
| jump_addr | output | 16 | Jump target address |
| jump_x | output | 8 | Slot number times 16 |
| status | output | 2 | 0 idle, 1 seek, 2 load, 3 done |

## Verification
Some internal faults have no visible effect until loading ends. If the sector counter or the captured count is wrong, the first sign at the ports is a request with the wrong sector or page number, an extra request, or a missing request before `jump_valid` rises. Other faults show up much sooner. A stepper with a bad reload value gives pulse spacing that differs from `settle_cycles`+1, and this appears within the first two pulses. A miscount in the stepper is only found when the first request appears: at that point the number of pulses seen so far is not NUM_STEPS. A mistake in the enable ladder is seen within four cycles of start.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_LOAD = 2'd2,
    ST_DONE = 2'd3
  } boot_state_t;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2,
    LD_END  = 2'd3
  } load_phase_t;
endpackage

// File: rtl/boot_drive_enable.sv
module boot_drive_enable #(
  parameter int NUM_EN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  output logic [NUM_EN-1:0] en_vec,
  output logic              all_on
);
  localparam int CW = $clog2(NUM_EN + 1);

  logic [CW-1:0] lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= '0;
    end else if (lvl == '0) begin
      if (kick) lvl <= CW'(1);
    end else if (lvl < CW'(NUM_EN)) begin
      lvl <= lvl + CW'(1);
    end
  end

  for (genvar i = 0; i < NUM_EN; i++) begin : g_en
    assign en_vec[i] = (lvl > CW'(i));
  end

  assign all_on = (lvl == CW'(NUM_EN));

  // A later enable never stands without every earlier one (R2)
  for (genvar j = 1; j < NUM_EN; j++) begin : g_ord
    a_r2_ladder_order: assert property (@(posedge clk) disable iff (!rst_n)
      en_vec[j] |-> en_vec[j-1]);
    a_r2_ladder_holds: assert property (@(posedge clk) disable iff (!rst_n)
      en_vec[j-1] |=> en_vec[j-1]);
  end
endmodule

// File: rtl/boot_head_stepper.sv
module boot_head_stepper #(
  parameter int NUM_STEPS = 80,
  parameter int SETTLE_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                step_pulse,
  output logic                finished
);
  localparam int LW = $clog2(NUM_STEPS + 1);

  logic [LW-1:0]       left;
  logic [SETTLE_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left       <= LW'(NUM_STEPS);
      wait_cnt   <= '0;
      step_pulse <= 1'b0;
      finished   <= 1'b0;
    end else if (go && !finished) begin
      if (wait_cnt == '0) begin
        if (left == '0) begin
          finished   <= 1'b1;
          step_pulse <= 1'b0;
        end else begin
          step_pulse <= 1'b1;
          left       <= left - LW'(1);
          wait_cnt   <= settle_cycles;
        end
      end else begin
        wait_cnt   <= wait_cnt - SETTLE_W'(1);
        step_pulse <= 1'b0;
      end
    end else begin
      step_pulse <= 1'b0;
    end
  end

  // R3: no pulse once the burst has ended, and finishing is permanent
  a_r3_quiet_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> !step_pulse);
  a_r3_finish_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> finished);
  // R3: a pulse is only produced while stepping is enabled
  a_r3_pulse_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> $past(go));
endmodule

// File: rtl/boot_sector_sched.sv
module boot_sector_sched
  import boot_seq_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  BASE_PAGE = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [CNT_W-1:0] req_sector,
  output logic [CNT_W-1:0] req_page,
  input  logic             resp_valid,
  output logic             resp_ready,
  input  logic             resp_ok,
  input  logic [CNT_W-1:0] resp_byte0,
  output logic             finished
);
  load_phase_t      ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] total;
  logic [CNT_W:0]   nxt;
  logic [CNT_W:0]   limit;

  assign nxt   = {1'b0, cnt} + (CNT_W+1)'(1);
  assign limit = (cnt == '0) ? {1'b0, resp_byte0} : {1'b0, total};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= LD_IDLE;
      cnt   <= '0;
      total <= '0;
    end else begin
      unique case (ph)
        LD_IDLE: if (go) ph <= LD_REQ;
        LD_REQ:  if (req_ready) ph <= LD_WAIT;
        LD_WAIT: begin
          if (resp_valid) begin
            if (resp_ok) begin
              if (cnt == '0) total <= resp_byte0;
              cnt <= nxt[CNT_W-1:0];
              ph  <= (nxt >= limit) ? LD_END : LD_REQ;
            end else begin
              ph <= LD_REQ;
            end
          end
        end
        LD_END:  ph <= LD_END;
        default: ph <= LD_IDLE;
      endcase
    end
  end

  assign req_valid  = (ph == LD_REQ);
  assign resp_ready = (ph == LD_WAIT);
  assign finished   = (ph == LD_END);
  assign req_sector = cnt;
  assign req_page   = BASE_PAGE[CNT_W-1:0] + cnt;

  // R5: an offered request holds still until taken
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_sector) && $stable(req_page));
  // R5: never offer a request and wait for a result together
  a_r5_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && resp_ready));
  // R6: a failed result brings back the same sector
  a_r6_retry_same: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready && !resp_ok |=> req_valid && $stable(req_sector));
  // R4: a good result moves to the next sector or ends
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready && resp_ok |=> req_sector == $past(req_sector) + CNT_W'(1));
  // R8: finishing is permanent and silent
  a_r8_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> finished && !req_valid && !resp_ready);
endmodule

// File: rtl/boot_load_seq.sv
module boot_load_seq
  import boot_seq_pkg::*;
#(
  parameter int         NUM_STEPS = 80,
  parameter int         SETTLE_W  = 16,
  parameter int         SLOT_W    = 3,
  parameter int         CNT_W     = 8,
  parameter logic [7:0] BASE_PAGE = 8'h08
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SLOT_W-1:0]   slot_id,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                rd_mode,
  output logic                latch_mode,
  output logic                drive1_sel,
  output logic                motor_on,
  output logic                step_pulse,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [CNT_W-1:0]    req_sector,
  output logic [CNT_W-1:0]    req_page,
  input  logic                resp_valid,
  output logic                resp_ready,
  input  logic                resp_ok,
  input  logic [CNT_W-1:0]    resp_byte0,
  output logic                jump_valid,
  output logic [15:0]         jump_addr,
  output logic [7:0]          jump_x,
  output logic [1:0]          status
);
  localparam int NUM_EN = 4;

  boot_state_t       state;
  logic              kick;
  logic [NUM_EN-1:0] en_vec;
  logic              en_all;
  logic              seek_fin;
  logic              load_fin;
  logic [SLOT_W-1:0] slot_q;

  assign kick = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      slot_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SEEK;
          slot_q <= slot_id;
        end
        ST_SEEK: if (seek_fin) state <= ST_LOAD;
        ST_LOAD: if (load_fin) state <= ST_DONE;
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  boot_drive_enable #(.NUM_EN(NUM_EN)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (kick),
    .en_vec (en_vec),
    .all_on (en_all)
  );

  assign rd_mode    = en_vec[0];
  assign latch_mode = en_vec[1];
  assign drive1_sel = en_vec[2];
  assign motor_on   = en_vec[3];

  boot_head_stepper #(.NUM_STEPS(NUM_STEPS), .SETTLE_W(SETTLE_W)) u_stepper (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            ((state == ST_SEEK) && en_all),
    .settle_cycles (settle_cycles),
    .step_pulse    (step_pulse),
    .finished      (seek_fin)
  );

  boot_sector_sched #(.CNT_W(CNT_W), .BASE_PAGE(BASE_PAGE)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (state == ST_LOAD),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_sector (req_sector),
    .req_page   (req_page),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_ok    (resp_ok),
    .resp_byte0 (resp_byte0),
    .finished   (load_fin)
  );

  assign jump_valid = (state == ST_DONE);
  assign jump_addr  = {BASE_PAGE, 8'h01};
  assign jump_x     = 8'({slot_q, 4'b0000});
  assign status     = 2'(state);

  // R3: steps only with the drive fully enabled
  a_r3_step_with_motor: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> motor_on && drive1_sel);
  // R3: no request while the head is still moving
  a_r3_no_req_in_seek: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1) |-> !req_valid);
  // R8 / R9: done is terminal and quiet
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> jump_valid && !req_valid);
  // R10: a start outside idle does not bring the block back to idle
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0) && start |=> status != 2'd0);
  // R2: the drive stays enabled through load and done
  a_r2_motor_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> motor_on);
endmodule

// File: tb/boot_load_seq_bench.sv
module boot_load_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  slot_id = '0;
  logic [15:0] settle_cycles = '0;
  logic        rd_mode, latch_mode, drive1_sel, motor_on, step_pulse;
  logic        req_valid, resp_ready, jump_valid;
  logic        req_ready = 1'b0, resp_valid = 1'b0, resp_ok = 1'b0;
  logic [7:0]  req_sector, req_page, resp_byte0 = '0, jump_x;
  logic [15:0] jump_addr;
  logic [1:0]  status;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  boot_load_seq u_boot_load_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_id(slot_id),
    .settle_cycles(settle_cycles), .rd_mode(rd_mode), .latch_mode(latch_mode),
    .drive1_sel(drive1_sel), .motor_on(motor_on), .step_pulse(step_pulse),
    .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
    .req_page(req_page), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_ok(resp_ok), .resp_byte0(resp_byte0), .jump_valid(jump_valid),
    .jump_addr(jump_addr), .jump_x(jump_x), .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sectors_for(input int cnt);
    return (cnt <= 1) ? 1 : cnt;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_case(input int slot, input int settle, input int count,
                          input int fail_pct, input bit poke_start);
    int pulses, last_pulse, t, want, got_ok, exp_sec, d, guard;
    bit gap_ok;
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b0; resp_valid = 1'b0;
    slot_id = 3'(slot); settle_cycles = 16'(settle);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rd_mode && !latch_mode && !drive1_sel && !motor_on && !step_pulse,
        "R1", "drive levels low", {rd_mode, latch_mode, drive1_sel, motor_on}, 0);
    chk(!req_valid && !resp_ready && !jump_valid && status == 2'd0,
        "R1", "idle status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 2'd0 && !rd_mode, "R1", "idle after reset", status, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 ladder
    chk({rd_mode, latch_mode, drive1_sel, motor_on} == 4'b1000, "R2", "step1",
        {rd_mode, latch_mode, drive1_sel, motor_on}, 8);
    chk(status == 2'd1, "R9", "seek status", status, 1);
    @(negedge clk);
    chk({rd_mode, latch_mode, drive1_sel, motor_on} == 4'b1100, "R2", "step2",
        {rd_mode, latch_mode, drive1_sel, motor_on}, 12);
    @(negedge clk);
    chk({rd_mode, latch_mode, drive1_sel, motor_on} == 4'b1110, "R2", "step3",
        {rd_mode, latch_mode, drive1_sel, motor_on}, 14);
    @(negedge clk);
    chk({rd_mode, latch_mode, drive1_sel, motor_on} == 4'b1111, "R2", "step4",
        {rd_mode, latch_mode, drive1_sel, motor_on}, 15);
    // R3 stepping
    pulses = 0; last_pulse = -1; t = 0; gap_ok = 1'b1;
    while (!req_valid && t < 20000) begin
      if (step_pulse) begin
        if (last_pulse >= 0 && (t - last_pulse) != settle + 1) gap_ok = 1'b0;
        last_pulse = t;
        pulses++;
      end
      t++;
      @(negedge clk);
    end
    chk(pulses == 80, "R3", "step count", pulses, 80);
    chk(gap_ok, "R3", "step spacing", t, settle + 1);
    chk(status == 2'd2, "R9", "load status", status, 2);
    // load loop
    want = sectors_for(count); got_ok = 0; exp_sec = 0; guard = 0;
    while (!jump_valid && guard < 400) begin
      guard++;
      if (!req_valid) begin
        @(negedge clk);
        continue;
      end
      chk(req_sector == 8'(exp_sec), "R4", "sector", req_sector, exp_sec);
      chk(req_page == 8'(8 + exp_sec), "R4", "page", req_page, 8 + exp_sec);
      chk(!resp_ready, "R5", "resp_ready during offer", resp_ready, 0);
      d = $urandom % 4;
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        chk(req_valid && req_sector == 8'(exp_sec), "R5", "hold under back-pressure",
            req_sector, exp_sec);
      end
      if (poke_start) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(status == 2'd2 && req_sector == 8'(exp_sec), "R10", "start ignored",
            status, 2);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk(!req_valid && resp_ready, "R5", "waiting for result", resp_ready, 1);
      d = $urandom % 3;
      repeat (d) @(negedge clk);
      resp_valid = 1'b1;
      resp_ok = (($urandom % 100) >= 32'(fail_pct));
      resp_byte0 = (got_ok == 0) ? 8'(count) : 8'($urandom % 4);
      @(negedge clk);
      resp_valid = 1'b0;
      if (resp_ok) begin
        got_ok++;
        exp_sec++;
      end else begin
        chk(req_valid && req_sector == 8'(exp_sec), "R6", "retry same sector",
            req_sector, exp_sec);
      end
      if (got_ok >= want) @(negedge clk);
    end
    chk(got_ok == want, "R7", "sectors loaded", got_ok, want);
    chk(jump_valid, "R8", "jump_valid", jump_valid, 1);
    chk(jump_addr == 16'h0801, "R8", "jump_addr", jump_addr, 16'h0801);
    chk(jump_x == 8'(slot * 16), "R8", "jump_x", jump_x, slot * 16);
    chk(status == 2'd3, "R9", "done status", status, 3);
    repeat (3) @(negedge clk);
    chk(!req_valid && jump_valid && motor_on && rd_mode, "R8", "quiet after done",
        req_valid, 0);
    chk(motor_on && drive1_sel && latch_mode && rd_mode, "R2", "levels held",
        {rd_mode, latch_mode, drive1_sel, motor_on}, 15);
  endtask

  initial begin
    void'($urandom(32'd7001));
    run_case(6, 2, 1, 0, 1'b0);
    run_case(6, 0, 0, 0, 1'b1);
    run_case(3, 1, 3, 40, 1'b0);
    run_case(0, 4, 2, 0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      run_case(int'($urandom % 8), int'($urandom % 5), int'($urandom % 6), 25,
               1'(($urandom % 2)));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule